// File: doc/BRIEF.md
# Asynchronous Registered Programmable Logic Array

This block models a small programmable logic device with ten output cells driven from one shared programmable AND plane. Every cell owns eight product terms. One term enables the cell's pin driver. Three terms supply the register's own clock, an asynchronous set and an asynchronous reset. The remaining four are ORed into a data sum, and a per-cell polarity bit can invert that sum. A fuse vector and a polarity vector are held steady while the block runs and define all of this.

There is no mode bit to choose between registered and combinational output. A cell whose set term and reset term are both true stops using its register, and its pin carries the polarity-adjusted sum directly, still under tristate control. Each bidirectional pin is split into a sensed input, a driven value and a driver enable. The AND plane is fed from the sensed pin value, so a pin that is not driven can act as an extra input.

A preload path makes registered states easy to test. With the output enable pin high the pins float. The tester forces values onto them and holds the active-low preload pin low for at least a set number of sampling-clock edges, and every register then copies its pin.

Top module: `ra_pld_array`

## Requirements
- R1: While `rst_ni` is low, every cell register is cleared, so a registered cell shows 0 on `pin_o`.
- R2: Product term t of cell c uses fuse bits starting at index (c*8+t)*N_COL, with N_COL = 2*(N_IN+N_CELL). Column 2k is `in_i[k]` and column 2k+1 is its complement. Column 2*N_IN+2k is `pin_i[k]` and the next column is its complement. A fuse bit of 1 connects its column. A term is the AND of its connected columns, so a term with every column connected is false and a term with no column connected is true. The term roles are: 0 pin enable, 1 set, 2 reset, 3 clock, 4 to 7 data.
- R3: `pin_oe_o[c]` is 1 only when cell c's enable term is true and `oe_ni` is low. Either one can therefore gate the pin alone.
- R4: When the set and reset terms of a cell are both true, `pin_o[c]` follows the OR of its four data terms combinationally. The sum is inverted when `pol_i[c]` is 1.
- R5: A true reset term holds the register at 0 and overrides clock, set and preload. A set term that rises while reset is false forces the register to 1, and clock edges do not change it while set stays true. Both act without any clock.
- R6: With set and reset false, the register takes (data sum XOR `pol_i[c]`) on each rising edge of the cell's clock term, and it holds its value between edges. Outside bypass, `pin_o[c]` shows the register.
- R7: The preload pin `pl_ni` must be held low for PL_MIN_CYC rising edges of `clk_i`. When that happens, every register with set and reset false loads its `pin_i` value once. A shorter low pulse has no effect.
- R8: The feedback columns of the AND plane are taken from `pin_i`. A floated pin can therefore drive other cells' terms, including a register's clock term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock that measures the preload pulse |
| rst_ni | input | 1 | Active-low asynchronous clear of registers and preload timer |
| fuse_i | input | N_CELL*8*N_COL | AND-plane fuse map, 1 = column connected |
| pol_i | input | N_CELL | Per-cell polarity, 1 = inverted output |
| in_i | input | N_IN | Dedicated logic inputs |
| pin_i | input | N_CELL | Sensed value of each cell pin |
| oe_ni | input | 1 | Active-low global output enable |
| pl_ni | input | 1 | Active-low preload request |
| pin_o | output | N_CELL | Value each cell drives onto its pin |
| pin_oe_o | output | N_CELL | Driver enable for each cell pin |

## Verification
The assertions sample the asynchronous cell state on `clk_i`, so they assume every input changes once per clock, away from the rising edge, with all changes made together. They also assume that a set term never rises in the same step in which its reset term falls, and that the fuse map changes only while reset is held. The stimulus applies each change on the falling edge and loads every new fuse map inside a reset pulse. It never builds a data term from an input that moves together with that cell's clock term. In the random phase, the clock input's columns are removed from the data terms so that capture never races.

// File: rtl/rapld_pkg.sv
package rapld_pkg;
  localparam int TERMS_PER_CELL = 8;
  localparam int T_OE   = 0;
  localparam int T_SET  = 1;
  localparam int T_RST  = 2;
  localparam int T_CLK  = 3;
  localparam int T_DAT0 = 4;
  localparam int N_DAT  = 4;
endpackage

// File: rtl/pld_and_plane.sv
module pld_and_plane
  import rapld_pkg::*;
#(
  parameter int N_IN   = 10,
  parameter int N_CELL = 10,
  localparam int N_COL  = 2 * (N_IN + N_CELL),
  localparam int N_TERM = N_CELL * TERMS_PER_CELL
) (
  input  logic [N_TERM*N_COL-1:0] fuse_i,
  input  logic [N_IN-1:0]         in_i,
  input  logic [N_CELL-1:0]       fb_i,
  output logic [N_TERM-1:0]       term_o
);
  logic [N_COL-1:0] col;

  for (genvar k = 0; k < N_IN; k++) begin : g_in_col
    assign col[2*k]   = in_i[k];
    assign col[2*k+1] = ~in_i[k];
  end

  for (genvar k = 0; k < N_CELL; k++) begin : g_fb_col
    assign col[2*N_IN+2*k]   = fb_i[k];
    assign col[2*N_IN+2*k+1] = ~fb_i[k];
  end

  // unconnected columns read as 1, so an empty term is true
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign term_o[t] = &(col | ~fuse_i[t*N_COL +: N_COL]);
  end
endmodule

// File: rtl/pld_preload_timer.sv
module pld_preload_timer #(
  parameter int PL_MIN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pl_ni,
  output logic load_o
);
  localparam int CNT_W = $clog2(PL_MIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TRIG = CNT_W'(PL_MIN_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(PL_MIN_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      load_o <= 1'b0;
    end else if (pl_ni) begin
      cnt    <= '0;
      load_o <= 1'b0;
    end else begin
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      load_o <= (cnt == CNT_TRIG);
    end
  end

  AST_LOAD_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o); // R7
  AST_LOAD_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_ni |=> !load_o); // R7
endmodule

// File: rtl/pld_cell.sv
module pld_cell
  import rapld_pkg::*;
(
  input  logic                      rst_ni,
  input  logic [TERMS_PER_CELL-1:0] terms_i,
  input  logic                      pol_i,
  input  logic                      pin_i,
  input  logic                      load_i,
  input  logic                      oe_ni,
  output logic                      pin_o,
  output logic                      oe_o,
  output logic                      q_o
);
  logic clk_t, set_t, rst_t, bypass, d;

  assign clk_t  = terms_i[T_CLK];
  assign set_t  = terms_i[T_SET];
  assign rst_t  = terms_i[T_RST];
  assign bypass = set_t & rst_t;
  assign d      = (|terms_i[T_DAT0 +: N_DAT]) ^ pol_i;

  // reset term wins, so a bypassed cell keeps its register cleared
  always_ff @(posedge clk_t or posedge rst_t or posedge set_t or posedge load_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (rst_t)  q_o <= 1'b0;
    else if (set_t)  q_o <= 1'b1;
    else if (load_i) q_o <= pin_i;
    else             q_o <= d;
  end

  assign pin_o = bypass ? d : q_o;
  assign oe_o  = terms_i[T_OE] & ~oe_ni;
endmodule

// File: rtl/ra_pld_array.sv
module ra_pld_array
  import rapld_pkg::*;
#(
  parameter int N_IN       = 10,
  parameter int N_CELL     = 10,
  parameter int PL_MIN_CYC = 4,
  localparam int N_COL  = 2 * (N_IN + N_CELL),
  localparam int N_TERM = N_CELL * TERMS_PER_CELL,
  localparam int FUSE_W = N_TERM * N_COL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FUSE_W-1:0] fuse_i,
  input  logic [N_CELL-1:0] pol_i,
  input  logic [N_IN-1:0]   in_i,
  input  logic [N_CELL-1:0] pin_i,
  input  logic              oe_ni,
  input  logic              pl_ni,
  output logic [N_CELL-1:0] pin_o,
  output logic [N_CELL-1:0] pin_oe_o
);
  logic [N_TERM-1:0] term;
  logic [N_CELL-1:0] cell_q;
  logic              pl_load;

  pld_and_plane #(.N_IN(N_IN), .N_CELL(N_CELL)) u_plane (
    .fuse_i (fuse_i),
    .in_i   (in_i),
    .fb_i   (pin_i),
    .term_o (term)
  );

  pld_preload_timer #(.PL_MIN_CYC(PL_MIN_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pl_ni  (pl_ni),
    .load_o (pl_load)
  );

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    logic set_t, rst_t;
    assign set_t = term[c*TERMS_PER_CELL + T_SET];
    assign rst_t = term[c*TERMS_PER_CELL + T_RST];

    pld_cell u_cell (
      .rst_ni  (rst_ni),
      .terms_i (term[c*TERMS_PER_CELL +: TERMS_PER_CELL]),
      .pol_i   (pol_i[c]),
      .pin_i   (pin_i[c]),
      .load_i  (pl_load),
      .oe_ni   (oe_ni),
      .pin_o   (pin_o[c]),
      .oe_o    (pin_oe_o[c]),
      .q_o     (cell_q[c])
    );

    AST_RST_TERM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_t |-> !cell_q[c]); // R5
    AST_SET_RISE_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(set_t) && !rst_t) |-> cell_q[c]); // R5
    AST_OE_PIN_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_oe_o[c] |-> !oe_ni); // R3
  end
endmodule

// File: tb/ra_pld_array_test.sv
module ra_pld_array_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 10;
  localparam int N_CELL = 10;
  localparam int PL_MIN = 4;
  localparam int N_COL = 2 * (N_IN + N_CELL);
  localparam int FUSE_W = N_CELL * 8 * N_COL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FUSE_W-1:0] fuse = '1;
  logic [N_CELL-1:0] pol = '0;
  logic [N_IN-1:0] in_v = '0;
  logic [N_CELL-1:0] pin_v = '0;
  logic oe_n = 1'b0;
  logic pl_n = 1'b1;
  logic [N_CELL-1:0] pin_o, pin_oe;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ra_pld_array #(.N_IN(N_IN), .N_CELL(N_CELL), .PL_MIN_CYC(PL_MIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fuse_i(fuse), .pol_i(pol), .in_i(in_v),
    .pin_i(pin_v), .oe_ni(oe_n), .pl_ni(pl_n), .pin_o(pin_o), .pin_oe_o(pin_oe)
  );

  task automatic chk(string req, logic [N_CELL-1:0] act, logic [N_CELL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  function automatic int cin(int k, int neg);  return 2*k + neg; endfunction
  function automatic int cfb(int k, int neg);  return 2*N_IN + 2*k + neg; endfunction
  function automatic int base(int c, int t);   return (c*8 + t) * N_COL; endfunction

  task automatic t_never(int c, int t);  fuse[base(c,t) +: N_COL] = '1; endtask
  task automatic t_always(int c, int t); fuse[base(c,t) +: N_COL] = '0; endtask
  task automatic t_lit(int c, int t, int col);
    fuse[base(c,t) +: N_COL] = '0;
    fuse[base(c,t) + col] = 1'b1;
  endtask

  // term value straight from the column definition
  function automatic logic term_val(int c, int t);
    for (int j = 0; j < N_COL; j++) begin
      logic v;
      if (j < 2*N_IN) v = in_v[j/2] ^ logic'(j % 2);
      else            v = pin_v[(j-2*N_IN)/2] ^ logic'(j % 2);
      if (fuse[base(c,t) + j] && !v) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic exp_d(int c);
    logic s = 1'b0;
    for (int t = 4; t < 8; t++) s |= term_val(c, t);
    return s ^ pol[c];
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic settle(); #1; endtask

  task automatic cfg_reset();
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic cfg_blank();
    rst_n = 1'b0;
    fuse = '1;
    pol = '0;
    in_v = '0;
    pin_v = '0;
    oe_n = 1'b0;
    pl_n = 1'b1;
  endtask

  task automatic pulse_pl(int n);
    tick();
    pl_n = 1'b0;
    repeat (n) tick();
    pl_n = 1'b1;
    repeat (2) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [N_CELL-1:0] exp_q;
    logic [N_CELL-1:0] m;

    // R1 / R2: blank map, all terms false
    cfg_blank();
    cfg_reset();
    settle();
    chk("R1 reset clears registers", pin_o, '0);
    chk("R2 fully connected term false", pin_oe, '0);

    // R2 / R3: enable term forms and the pin gate
    cfg_blank();
    t_always(0, 0);
    t_lit(1, 0, cin(0, 0));
    t_lit(2, 0, cin(0, 1));
    cfg_reset();
    settle();
    chk("R2 empty term true, literal terms", pin_oe, 10'b0000000101);
    tick(); in_v[0] = 1'b1; settle();
    chk("R2 true column follows input", pin_oe, 10'b0000000011);
    tick(); oe_n = 1'b1; settle();
    chk("R3 oe pin high floats all", pin_oe, '0);
    tick(); oe_n = 1'b0; in_v[0] = 1'b0; settle();
    chk("R3 term alone gates", pin_oe, 10'b0000000101);

    // R4: bypass with both polarities
    cfg_blank();
    for (int c = 1; c <= 2; c++) begin
      t_always(c, 0); t_always(c, 1); t_always(c, 2);
      t_lit(c, 4, cin(1, 0));
      t_lit(c, 5, cin(2, 1));
    end
    pol[2] = 1'b1;
    cfg_reset();
    m = 10'b0000000110;
    for (int v = 0; v < 4; v++) begin
      logic s;
      tick();
      in_v[1] = v[0];
      in_v[2] = v[1];
      settle();
      s = v[0] | ~v[1];
      chk("R4 bypass follows sum", pin_o & m, {7'b0, ~s, s, 1'b0});
    end

    // R5 / R6: cell 3 set=in3 reset=in4 clk=in5 data=in6
    cfg_blank();
    t_always(3, 0);
    t_lit(3, 1, cin(3, 0));
    t_lit(3, 2, cin(4, 0));
    t_lit(3, 3, cin(5, 0));
    t_lit(3, 4, cin(6, 0));
    cfg_reset();
    m = 10'b0000001000;
    settle();
    chk("R1 cell idle after reset", pin_o & m, '0);
    tick(); in_v[6] = 1'b1; tick(); in_v[5] = 1'b1; settle();
    chk("R6 capture 1 on clock rise", pin_o & m, m);
    tick(); in_v[6] = 1'b0; settle();
    chk("R6 hold between edges", pin_o & m, m);
    tick(); in_v[5] = 1'b0; tick(); in_v[5] = 1'b1; settle();
    chk("R6 capture 0 on clock rise", pin_o & m, '0);
    tick(); in_v[5] = 1'b0; tick(); in_v[3] = 1'b1; settle();
    chk("R5 set forces 1", pin_o & m, m);
    tick(); in_v[5] = 1'b1; settle();
    chk("R5 set overrides clock", pin_o & m, m);
    tick(); in_v[5] = 1'b0; tick(); in_v[3] = 1'b0; settle();
    chk("R5 state kept after set release", pin_o & m, m);
    tick(); in_v[4] = 1'b1; settle();
    chk("R5 reset forces 0", pin_o & m, '0);
    tick(); in_v[6] = 1'b1; tick(); in_v[5] = 1'b1; settle();
    chk("R5 reset overrides clock", pin_o & m, '0);
    tick(); in_v[5] = 1'b0; tick(); in_v[4] = 1'b0; tick(); pol[3] = 1'b1; settle();
    chk("R6 polarity change needs an edge", pin_o & m, '0);
    tick(); in_v[5] = 1'b1; settle();
    chk("R6 inverted capture of 1 sum", pin_o & m, '0);
    tick(); in_v[5] = 1'b0; in_v[6] = 1'b0; tick(); in_v[5] = 1'b1; settle();
    chk("R6 inverted capture of 0 sum", pin_o & m, m);

    // R8: pin 5 floated and used as input
    cfg_blank();
    t_always(4, 0); t_always(4, 1); t_always(4, 2); t_lit(4, 4, cfb(5, 0));
    t_always(6, 0); t_always(6, 1); t_always(6, 2); t_lit(6, 4, cfb(5, 1));
    t_always(7, 0); t_lit(7, 3, cfb(5, 0)); t_lit(7, 4, cin(7, 0));
    cfg_reset();
    m = 10'b0011010000;
    tick(); in_v[7] = 1'b1; settle();
    chk("R8 floated pin not driven", pin_oe & 10'b0000100000, '0);
    tick(); pin_v[5] = 1'b1; settle();
    chk("R8 feedback high drives terms", pin_o & m, 10'b0010010000);
    tick(); pin_v[5] = 1'b0; settle();
    chk("R8 feedback low drives terms", pin_o & m, 10'b0011000000);

    // R7: preload
    cfg_blank();
    for (int c = 0; c < N_CELL; c++) t_always(c, 0);
    cfg_reset();
    tick(); oe_n = 1'b1; pin_v = 10'h2B5; settle();
    chk("R3 pins float for preload", pin_oe, '0);
    pulse_pl(PL_MIN - 1);
    oe_n = 1'b0; settle();
    chk("R7 short pulse ignored", pin_o, '0);
    tick(); oe_n = 1'b1;
    pulse_pl(PL_MIN);
    oe_n = 1'b0; settle();
    chk("R7 minimum pulse loads", pin_o, 10'h2B5);
    tick(); oe_n = 1'b1; pin_v = 10'h14A;
    pulse_pl(PL_MIN + 3);
    oe_n = 1'b0; settle();
    chk("R7 long pulse loads", pin_o, 10'h14A);
    chk("R3 readback enables", pin_oe, '1);

    // R6 / R2: random sparse maps, clock on in9
    cfg_blank();
    void'($urandom(32'd2024));
    for (int c = 0; c < N_CELL; c++) begin
      t_always(c, 0);
      t_lit(c, 3, cin(9, 0));
      for (int t = 4; t < 8; t++)
        for (int j = 0; j < N_COL; j++)
          fuse[base(c,t) + j] = (j != cin(9,0)) && (j != cin(9,1)) && (($urandom() % 8) == 0);
      pol[c] = 1'($urandom());
    end
    cfg_reset();
    exp_q = '0;
    for (int it = 0; it < 60; it++) begin
      tick();
      in_v = {1'b0, 9'($urandom())};
      pin_v = 10'($urandom());
      settle();
      chk("R6 random hold without edge", pin_o, exp_q);
      tick();
      in_v[9] = 1'b1;
      settle();
      for (int c = 0; c < N_CELL; c++) exp_q[c] = exp_d(c);
      chk("R6 R2 random capture", pin_o, exp_q);
    end

    finish_run();
  end
endmodule